// File: doc/BRIEF.md
# Column Buffer Phase Sequencer

This block produces the control waveform for one column-line output buffer during each line period of a display panel. A line-start strobe begins a fixed run of phases. Each phase lasts a number of clock cycles taken from its own length input. The run ends in an idle state in which every control line is low. Two buffer styles are supported, and the style input picks one of them when a line starts.

The dynamic style has three phases. In the first, the buffer reset is high, which empties the load and routes the high supply onto the sense node. In the second, reset drops and the data voltage is routed in while the driver stays off. In the third, the driver is enabled and acts as a follower. The static style has two phases: a discharge with the driver off, then a drive. A single all-low cycle separates every pair of adjacent phases. The reset line doubles as the multiplexer select. A busy flag covers the whole run.

Top module: `col_buf_phase_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `buf_reset`, `mux_sel`, `drv_en` and `busy` are all low, whatever `line_start` does during reset.
- R2: A `line_start` sampled high at a rising edge while `busy` is low starts a run. From that edge, `buf_reset` and `mux_sel` are high with `drv_en` low for max(`len_clear`,1) cycles.
- R3: In the dynamic style (`style_static` = 0), the clear phase and one gap cycle are followed by max(`len_settle`,1) cycles with `buf_reset`, `mux_sel` and `drv_en` all low.
- R4: The settle phase (or, in the static style, the clear phase) and one gap cycle are followed by max(`len_drive`,1) cycles with `drv_en` high and `buf_reset` low. On the next edge the block returns to idle with all outputs low.
- R5: A single gap cycle with `busy` high and the other three outputs low lies between each pair of adjacent phases. `buf_reset` and `drv_en` are never high in the same cycle.
- R6: In the static style (`style_static` = 1) the run is clear, gap, then drive, and `len_settle` has no effect.
- R7: A length input of zero gives a phase of exactly one cycle.
- R8: A `line_start` that arrives while `busy` is high is ignored, including one in the final drive cycle.
- R9: `busy` is high from the first clear cycle through the last drive cycle and is low otherwise. While `busy` is low, `buf_reset` and `drv_en` are low.
- R10: The style and all three lengths are captured at the edge that accepts a start. Changing them during a run does not alter that run.
- R11: `mux_sel` always equals `buf_reset`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Strobe that begins a line's phase run |
| style_static | input | 1 | 0 selects the three-phase dynamic buffer, 1 the two-phase static buffer |
| len_clear | input | LEN_W | Cycles in the clear/discharge phase (0 means 1) |
| len_settle | input | LEN_W | Cycles in the data-settle phase, dynamic style only (0 means 1) |
| len_drive | input | LEN_W | Cycles in the drive phase (0 means 1) |
| buf_reset | output | 1 | Buffer reset; high during the clear phase |
| mux_sel | output | 1 | Sense-node select: 1 routes the high supply, 0 routes data |
| drv_en | output | 1 | Driver enable; high during the drive phase |
| busy | output | 1 | High for the whole run |

## Verification
Runs of both styles use unequal phase lengths, so that a swapped or mis-selected length counter shows up at once as a wrong phase boundary. Runs with all lengths at one and all lengths at zero make the clamp visible, because both must give the same shortest waveform. A static run with a large settle value shows whether the settle phase leaks into that style. A dynamic run at the largest length tests the end of the counter. Strobes sent in the middle of a run with different style and lengths, and one sent in the final drive cycle, must leave the waveform unchanged. Those cases separate correct capture and busy gating from a design that restarts or re-reads its inputs.

// File: rtl/cbs_pkg.sv
`timescale 1ns/1ps
package cbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CLEAR  = 3'd1,
        PH_GAP_A  = 3'd2,
        PH_SETTLE = 3'd3,
        PH_GAP_B  = 3'd4,
        PH_DRIVE  = 3'd5
    } phase_e;

    typedef enum logic {
        STY_DYNAMIC = 1'b0,
        STY_STATIC  = 1'b1
    } style_e;

    typedef struct packed {
        logic busy;
        logic drv_en;
        logic mux_sel;
        logic buf_reset;
    } ctl_t;

    localparam int unsigned NUM_LEN    = 3;
    localparam int unsigned IDX_CLEAR  = 0;
    localparam int unsigned IDX_SETTLE = 1;
    localparam int unsigned IDX_DRIVE  = 2;

endpackage

// File: rtl/cbs_len_bank.sv
`timescale 1ns/1ps
// Holds one phase length per slot, captured when a run is accepted.
// A zero length is stored as one so that every phase lasts a cycle at least.
module cbs_len_bank
    import cbs_pkg::*;
#(
    parameter int unsigned LEN_W = 8,
    parameter int unsigned N     = NUM_LEN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [N-1:0][LEN_W-1:0]   raw,
    output logic [N-1:0][LEN_W-1:0]   held
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic [LEN_W-1:0] val_d;
        logic [LEN_W-1:0] val_q;

        always_comb begin
            val_d = val_q;
            if (load) begin
                val_d = (raw[i] == '0) ? LEN_ONE : raw[i];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= LEN_ONE;
            end else begin
                val_q <= val_d;
            end
        end

        assign held[i] = val_q;
    end

endmodule

// File: rtl/cbs_phase_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: walks clear -> gap -> settle -> gap -> drive (dynamic)
// or clear -> gap -> drive (static), counting each phase against its length.
module cbs_phase_fsm
    import cbs_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  style_e                          style_in,
    input  logic [NUM_LEN-1:0][LEN_W-1:0]   len,
    output logic                            accept,
    output phase_e                          phase
);

    localparam logic [LEN_W-1:0] CNT_ONE = LEN_W'(1);

    typedef struct packed {
        phase_e           phase;
        style_e           style;
        logic [LEN_W-1:0] cnt;
    } st_t;

    st_t              st_d;
    st_t              st_q;
    logic [LEN_W-1:0] len_cur;
    logic             last;

    always_comb begin
        unique case (st_q.phase)
            PH_CLEAR:  len_cur = len[IDX_CLEAR];
            PH_SETTLE: len_cur = len[IDX_SETTLE];
            PH_DRIVE:  len_cur = len[IDX_DRIVE];
            default:   len_cur = CNT_ONE;
        endcase
    end

    assign last   = ((st_q.cnt + CNT_ONE) == len_cur);
    assign accept = start && (st_q.phase == PH_IDLE);

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + CNT_ONE;
        unique case (st_q.phase)
            PH_IDLE: begin
                st_d.cnt = '0;
                if (accept) begin
                    st_d.phase = PH_CLEAR;
                    st_d.style = style_in;
                end
            end
            PH_CLEAR: begin
                if (last) begin
                    st_d.cnt   = '0;
                    st_d.phase = (st_q.style == STY_STATIC) ? PH_GAP_B : PH_GAP_A;
                end
            end
            PH_GAP_A: begin
                st_d.cnt   = '0;
                st_d.phase = PH_SETTLE;
            end
            PH_SETTLE: begin
                if (last) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_GAP_B;
                end
            end
            PH_GAP_B: begin
                st_d.cnt   = '0;
                st_d.phase = PH_DRIVE;
            end
            PH_DRIVE: begin
                if (last) begin
                    st_d.cnt   = '0;
                    st_d.phase = PH_IDLE;
                end
            end
            default: begin
                st_d.cnt   = '0;
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.style <= STY_DYNAMIC;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase = st_q.phase;

endmodule

// File: rtl/cbs_ctl_decode.sv
`timescale 1ns/1ps
// Maps the registered phase onto the buffer control lines.
module cbs_ctl_decode
    import cbs_pkg::*;
(
    input  phase_e phase,
    output ctl_t   ctl
);

    always_comb begin
        ctl           = '0;
        ctl.busy      = (phase != PH_IDLE);
        ctl.buf_reset = (phase == PH_CLEAR);
        ctl.mux_sel   = (phase == PH_CLEAR);
        ctl.drv_en    = (phase == PH_DRIVE);
    end

endmodule

// File: rtl/col_buf_phase_seq.sv
`timescale 1ns/1ps
module col_buf_phase_seq
    import cbs_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             style_static,
    input  logic [LEN_W-1:0] len_clear,
    input  logic [LEN_W-1:0] len_settle,
    input  logic [LEN_W-1:0] len_drive,
    output logic             buf_reset,
    output logic             mux_sel,
    output logic             drv_en,
    output logic             busy
);

    logic [NUM_LEN-1:0][LEN_W-1:0] raw_len;
    logic [NUM_LEN-1:0][LEN_W-1:0] held_len;
    logic                          accept;
    phase_e                        phase;
    ctl_t                          ctl;
    style_e                        style_sel;

    assign raw_len[IDX_CLEAR]  = len_clear;
    assign raw_len[IDX_SETTLE] = len_settle;
    assign raw_len[IDX_DRIVE]  = len_drive;
    assign style_sel           = style_static ? STY_STATIC : STY_DYNAMIC;

    cbs_len_bank #(.LEN_W(LEN_W), .N(NUM_LEN)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .raw   (raw_len),
        .held  (held_len)
    );

    cbs_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (line_start),
        .style_in (style_sel),
        .len      (held_len),
        .accept   (accept),
        .phase    (phase)
    );

    cbs_ctl_decode u_dec (
        .phase (phase),
        .ctl   (ctl)
    );

    assign buf_reset = ctl.buf_reset;
    assign mux_sel   = ctl.mux_sel;
    assign drv_en    = ctl.drv_en;
    assign busy      = ctl.busy;

endmodule

// File: rtl/col_buf_phase_seq_chk.sv
`timescale 1ns/1ps
module col_buf_phase_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic line_start,
    input logic buf_reset,
    input logic mux_sel,
    input logic drv_en,
    input logic busy
);

    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_reset && drv_en));

    assert_mux_tie_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel == buf_reset);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!buf_reset && !drv_en));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && line_start) |=> (busy && buf_reset && !drv_en));

    assert_clear_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_reset) |-> (busy && !drv_en));

    assert_drive_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_en) |-> !busy);

    assert_busy_begin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> buf_reset);

endmodule

bind col_buf_phase_seq col_buf_phase_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .buf_reset  (buf_reset),
    .mux_sel    (mux_sel),
    .drv_en     (drv_en),
    .busy       (busy)
);

// File: tb/sim_col_buf_phase_seq.sv
`timescale 1ns/1ps
module sim_col_buf_phase_seq;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_start = 1'b0;
    logic         style_static = 1'b0;
    logic [W-1:0] len_clear = '0;
    logic [W-1:0] len_settle = '0;
    logic [W-1:0] len_drive = '0;
    logic         buf_reset;
    logic         mux_sel;
    logic         drv_en;
    logic         busy;

    always #4 clk = ~clk;

    col_buf_phase_seq #(.LEN_W(W)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start   (line_start),
        .style_static (style_static),
        .len_clear    (len_clear),
        .len_settle   (len_settle),
        .len_drive    (len_drive),
        .buf_reset    (buf_reset),
        .mux_sel      (mux_sel),
        .drv_en       (drv_en),
        .busy         (busy)
    );

    // expected vector order: {busy, drv_en, mux_sel, buf_reset}
    typedef struct {
        logic [3:0] v;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    localparam logic [3:0] V_CLEAR = 4'b1011;
    localparam logic [3:0] V_GAP   = 4'b1000;
    localparam logic [3:0] V_DRIVE = 4'b1100;
    localparam logic [3:0] V_IDLE  = 4'b0000;

    function automatic int eff(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    task automatic push_n(input logic [3:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.v = v;
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    // accepted start: pushes the full expected waveform
    task automatic start_line(input bit st, input int a, input int b, input int c,
                              input string tag);
        @(negedge clk);
        line_start   = 1'b1;
        style_static = st;
        len_clear    = W'(a);
        len_settle   = W'(b);
        len_drive    = W'(c);
        push_n(V_CLEAR, eff(a), tag);
        push_n(V_GAP, 1, "R5");
        if (!st) begin
            push_n(V_GAP, eff(b), "R3");
            push_n(V_GAP, 1, "R5");
        end
        push_n(V_DRIVE, eff(c), st ? "R6" : "R4");
        @(negedge clk);
        line_start = 1'b0;
    endtask

    // start pulse that must be ignored: pushes nothing
    task automatic poke(input bit st, input int a, input int b, input int c);
        @(negedge clk);
        line_start   = 1'b1;
        style_static = st;
        len_clear    = W'(a);
        len_settle   = W'(b);
        len_drive    = W'(c);
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        if (mon_on && !done) begin
            #2;
            checks++;
            if (q.size() != 0) begin
                cur = q.pop_front();
            end else begin
                cur.v = V_IDLE;
                cur.tag = "R9";
            end
            if ({busy, drv_en, mux_sel, buf_reset} !== cur.v) begin
                errors++;
                $display("FAIL %s: busy/en/mux/rst got %b expected %b at %0t",
                         cur.tag, {busy, drv_en, mux_sel, buf_reset}, cur.v, $time);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 60000);
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        finish_run();
    end

    initial begin
        // R1: strobe held during reset must not start anything
        line_start = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if ({busy, drv_en, mux_sel, buf_reset} !== V_IDLE) begin
            errors++;
            $display("FAIL R1: got %b expected %b", {busy, drv_en, mux_sel, buf_reset}, V_IDLE);
        end
        line_start = 1'b0;
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4: dynamic, unequal lengths
        start_line(1'b0, 3, 2, 4, "R2");
        wait_idle();
        // R7: all ones, then all zeros give the same shortest run
        start_line(1'b0, 1, 1, 1, "R2");
        wait_idle();
        start_line(1'b0, 0, 0, 0, "R7");
        wait_idle();
        // R6: static, settle length must be ignored
        start_line(1'b1, 2, 7, 3, "R6");
        wait_idle();
        start_line(1'b1, 0, 5, 0, "R7");
        wait_idle();
        // R8 R10: strobes with other style/lengths during a run
        start_line(1'b0, 4, 3, 5, "R10");
        poke(1'b1, 9, 9, 9);
        repeat (3) @(negedge clk);
        poke(1'b0, 0, 20, 1);
        wait_idle();
        // R8: strobe in the last drive cycle
        start_line(1'b1, 2, 0, 2, "R8");
        while (q.size() != 0) @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        repeat (3) @(negedge clk);
        // counter end: largest length
        start_line(1'b0, 255, 1, 2, "R2");
        wait_idle();
        // back-to-back runs, static then dynamic
        start_line(1'b1, 5, 1, 1, "R6");
        wait_idle();
        start_line(1'b0, 1, 6, 2, "R3");
        wait_idle();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule